// File: doc/BRIEF.md
# Sensor Bus Request Frame Decoder

This block sits behind the line decoder of a slave on a two-wire sensor/actuator bus. It takes the recovered bit stream, one bit for each cycle in which `rx_valid` is high. It groups the bits into 14-bit master requests and checks the start bit, the end bit and the even parity of each request. It then decides whether the request is addressed to this slave. A clean request produces a one-cycle `frame_valid` pulse that carries the control bit, the address and the five information bits. When the request also addresses this slave, the block shifts out a 7-bit response that carries the four response bits the application presents.

The slave address is held in two redundant 6-bit copies, each laid out as {Sel, A4..A0}. The block captures them while reset is held low. If the copies agree, their value becomes the working address. If they differ, the slave works as address zero and raises `addr_fault`. With `ext_mode` high, request bit I3 must equal the stored Sel bit, which allows an A slave and a B slave to share one five-bit address.

Top module: `sensor_req_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `frame_valid`, `addr_match` and `tx_active` are 0 and `tx_bit` is 1.
- R2: Bits are taken in groups of 14 on cycles with `rx_valid` high, sent first to last as start, control, A4..A0, I4..I0, parity, end. After the 14th bit, a request that is clean gives `frame_valid` high for exactly one cycle, from the edge that took the 14th bit. In that cycle `req_ctrl`, `req_addr` (A4 in bit 4) and `req_info` (I4 in bit 4) are valid. A clean request has start = 0, end = 1, and parity equal to the XOR of the control, address and information bits.
- R3: A request with a start bit of 1, an end bit of 0 or a wrong parity gives no `frame_valid` and no response.
- R4: Cycles with `rx_valid` low do not advance the frame, whatever the value of `rx_bit`.
- R5: With `ext_mode` low, a request matches when A4..A0 equal the stored address bits [4:0], whatever the value of I3.
- R6: With `ext_mode` high, a match also requires I3 to equal the stored Sel bit (bit 5).
- R7: When the stored address bits [4:0] are zero, a request with control bit 0 never matches. A request with control bit 1 and address zero does match.
- R8: While reset is low, the two copies are captured. If they are equal, `slave_addr` takes the copy and `addr_fault` is 0. If they differ, `slave_addr` is 0 and `addr_fault` is 1. Changes to the copies after reset have no effect.
- R9: `addr_match` is high only together with `frame_valid`. In the cycle after a match, `tx_active` rises and stays high for 7 cycles. Over those cycles `tx_bit` carries 0, then `resp_info[3]` down to `resp_info[0]`, then their XOR, then 1. `resp_info` is sampled in the `frame_valid` cycle. `tx_bit` is 1 whenever `tx_active` is low.
- R10: A clean request that does not match raises no `tx_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the address copies are captured while it is low |
| ext_mode | input | 1 | 1 = six-bit addressing using I3 as the Sel bit |
| addr_copy0 | input | 6 | First stored address copy {Sel, A4..A0} |
| addr_copy1 | input | 6 | Second stored address copy {Sel, A4..A0} |
| rx_valid | input | 1 | Qualifies `rx_bit` |
| rx_bit | input | 1 | Received request bit |
| resp_info | input | 4 | Response bits, sampled in the `frame_valid` cycle |
| frame_valid | output | 1 | One-cycle pulse for a clean request |
| req_ctrl | output | 1 | Control bit: 0 = data/parameter, 1 = command |
| req_addr | output | 5 | Request address A4..A0 |
| req_info | output | 5 | Request information I4..I0 |
| addr_match | output | 1 | Request is addressed to this slave |
| slave_addr | output | 6 | Working address {Sel, A4..A0} |
| addr_fault | output | 1 | The two stored copies disagreed |
| tx_active | output | 1 | Response is being shifted out |
| tx_bit | output | 1 | Serial response bit; 1 when idle |

## Verification
The assertions check the following on every cycle: `frame_valid` lasts one cycle, and a response starts only after a matching request. The line stays high outside a response, and a data request is never matched at address zero. A faulted address reads as zero, and the working address does not move once reset is released. Only the bench's scenarios can show the rest, because each needs a known frame and a computed expectation: the field extraction, and the rejection of each kind of framing or parity error. They also cover the effect of the Sel bit in each mode, the serial order and parity of the response, and the immunity of the framing to idle cycles that carry noise.

// File: rtl/sreq_pkg.sv
// Package: shared widths and helpers for the sensor bus request decoder.
// Assumes request = start, control, address, info, parity, end.
package sreq_pkg;
    parameter int ADDR_W  = 5;   // request address bits
    parameter int INFO_W  = 5;   // request information bits
    parameter int RESP_W  = 4;   // response information bits
    parameter int SEL_IDX = 3;   // info bit used as sixth address bit

    // Even-parity bit over a vector of up to 16 bits.
    function automatic logic even_par(input logic [15:0] v);
        return ^v;
    endfunction
endpackage

// File: rtl/sreq_deser.sv
// Module: sreq_deser
// Collects FW qualified bits into a request. At the last bit it checks the
// start bit, the end bit and the even parity, and registers the payload
// (control, address, info). Assumes the bit stream is aligned to request
// boundaries from reset on.
module sreq_deser #(
    parameter int ADDR_W = sreq_pkg::ADDR_W,
    parameter int INFO_W = sreq_pkg::INFO_W,
    localparam int PW    = 1 + ADDR_W + INFO_W,
    localparam int FW    = PW + 3,
    localparam int CW    = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_bit,
    output logic          frame_ok,
    output logic [PW-1:0] payload
);
    logic [FW-2:0] sr;
    logic [CW-1:0] cnt;
    logic [FW-1:0] full;
    logic          clean;

    // Whole request as it stands once the current bit is included.
    assign full  = {sr, rx_bit};
    assign clean = !full[FW-1] && full[0] && !(^full[FW-2:1]);

    // Shift in qualified bits, count them, and judge the request at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            cnt      <= '0;
            frame_ok <= 1'b0;
            payload  <= '0;
        end else begin
            frame_ok <= 1'b0;
            if (rx_valid) begin
                sr <= full[FW-2:0];
                if (cnt == CW'(FW - 1)) begin
                    cnt      <= '0;
                    frame_ok <= clean;
                    payload  <= full[FW-2:2];
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    AST_FV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok); // R2
endmodule

// File: rtl/sreq_addr.sv
// Module: sreq_addr
// Captures the two redundant address copies while reset is low and keeps
// the copy only if both agree, else address zero with a fault flag. Decides
// whether a request addresses this slave, in five-bit or six-bit mode.
module sreq_addr #(
    parameter int ADDR_W = sreq_pkg::ADDR_W,
    localparam int SW    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     copy0,
    input  logic [SW-1:0]     copy1,
    input  logic              ext_mode,
    input  logic              req_ok,
    input  logic              req_ctrl,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_sel,
    output logic [SW-1:0]     slave_addr,
    output logic              addr_fault,
    output logic              hit
);
    logic addr_eq, sel_ok, zero_block;

    // Load the working address during reset; hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (copy0 == copy1) begin
                slave_addr <= copy0;
                addr_fault <= 1'b0;
            end else begin
                slave_addr <= '0;
                addr_fault <= 1'b1;
            end
        end
    end

    // Address comparison with optional Sel bit and the zero-address guard.
    always_comb begin
        addr_eq    = (req_addr == slave_addr[ADDR_W-1:0]);
        sel_ok     = !ext_mode || (req_sel == slave_addr[SW-1]);
        zero_block = !req_ctrl && (slave_addr[ADDR_W-1:0] == '0);
        hit        = req_ok && addr_eq && sel_ok && !zero_block;
    end

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_fault |-> (slave_addr == '0)); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(slave_addr)); // R8
endmodule

// File: rtl/sreq_resp_ser.sv
// Module: sreq_resp_ser
// Builds the response (start 0, info MSB first, even parity, end 1) on a
// start pulse and shifts it out one bit per cycle. The line idles high.
module sreq_resp_ser #(
    parameter int RESP_W = sreq_pkg::RESP_W,
    localparam int LEN   = RESP_W + 3,
    localparam int KW    = $clog2(LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RESP_W-1:0] info,
    output logic              tx_active,
    output logic              tx_bit
);
    logic [LEN-1:0] sr;
    logic [KW-1:0]  left;

    // Load the response on start, then shift it out MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '1;
            left <= '0;
        end else if (start) begin
            sr   <= {1'b0, info, sreq_pkg::even_par(16'(info)), 1'b1};
            left <= KW'(LEN);
        end else if (left != '0) begin
            sr   <= {sr[LEN-2:0], 1'b1};
            left <= left - KW'(1);
        end
    end

    assign tx_active = (left != '0);
    assign tx_bit    = tx_active ? sr[LEN-1] : 1'b1;

    AST_TX_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> $past(start)); // R9
    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> tx_bit); // R9
endmodule

// File: rtl/sensor_req_decoder.sv
// Module: sensor_req_decoder (top)
// Request decoder for a slave on a two-wire sensor/actuator bus: groups
// qualified bits into requests, checks their framing and parity, matches the
// address and answers a matched request with a serial response. Assumes one
// bit per rx_valid cycle, aligned to request boundaries after reset.
module sensor_req_decoder #(
    parameter int ADDR_W  = sreq_pkg::ADDR_W,
    parameter int INFO_W  = sreq_pkg::INFO_W,
    parameter int RESP_W  = sreq_pkg::RESP_W,
    parameter int SEL_IDX = sreq_pkg::SEL_IDX,
    localparam int SW     = ADDR_W + 1,
    localparam int PW     = 1 + ADDR_W + INFO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic [SW-1:0]     addr_copy0,
    input  logic [SW-1:0]     addr_copy1,
    input  logic              rx_valid,
    input  logic              rx_bit,
    input  logic [RESP_W-1:0] resp_info,
    output logic              frame_valid,
    output logic              req_ctrl,
    output logic [ADDR_W-1:0] req_addr,
    output logic [INFO_W-1:0] req_info,
    output logic              addr_match,
    output logic [SW-1:0]     slave_addr,
    output logic              addr_fault,
    output logic              tx_active,
    output logic              tx_bit
);
    logic [PW-1:0] payload;
    logic          hit;

    sreq_deser #(.ADDR_W(ADDR_W), .INFO_W(INFO_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit),
        .frame_ok (frame_valid),
        .payload  (payload)
    );

    // Split the registered payload into its fields.
    assign req_ctrl = payload[PW-1];
    assign req_addr = payload[PW-2 -: ADDR_W];
    assign req_info = payload[INFO_W-1:0];

    sreq_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .copy0      (addr_copy0),
        .copy1      (addr_copy1),
        .ext_mode   (ext_mode),
        .req_ok     (frame_valid),
        .req_ctrl   (req_ctrl),
        .req_addr   (req_addr),
        .req_sel    (req_info[SEL_IDX]),
        .slave_addr (slave_addr),
        .addr_fault (addr_fault),
        .hit        (hit)
    );

    assign addr_match = hit;

    sreq_resp_ser #(.RESP_W(RESP_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (hit),
        .info      (resp_info),
        .tx_active (tx_active),
        .tx_bit    (tx_bit)
    );

    AST_ZERO_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_match && !req_ctrl) |-> (slave_addr[ADDR_W-1:0] != '0)); // R7
endmodule

// File: tb/tb_sensor_req_decoder.sv
module tb_sensor_req_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b0;
    logic [5:0] addr_copy0 = '0, addr_copy1 = '0;
    logic       rx_valid = 1'b0, rx_bit = 1'b0;
    logic [3:0] resp_info = '0;
    logic       frame_valid, req_ctrl, addr_match, addr_fault, tx_active, tx_bit;
    logic [4:0] req_addr, req_info;
    logic [5:0] slave_addr;

    int n_chk = 0, n_bad = 0;
    logic [5:0] model_addr;

    always #2.5 clk = ~clk;

    sensor_req_decoder dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .addr_copy0(addr_copy0), .addr_copy1(addr_copy1),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .resp_info(resp_info),
        .frame_valid(frame_valid), .req_ctrl(req_ctrl), .req_addr(req_addr),
        .req_info(req_info), .addr_match(addr_match), .slave_addr(slave_addr),
        .addr_fault(addr_fault), .tx_active(tx_active), .tx_bit(tx_bit)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [13:0] mk(input logic cb, input logic [4:0] a,
                                       input logic [4:0] i, input int kind);
        logic [13:0] f;
        f = {1'b0, cb, a, i, ^{cb, a, i}, 1'b1};
        if (kind == 1) f[13] = 1'b1;
        if (kind == 2) f[0]  = 1'b0;
        if (kind == 3) f[1]  = ~f[1];
        return f;
    endfunction

    function automatic logic model_match(input logic cb, input logic [4:0] a,
                                         input logic [4:0] i);
        if (a != model_addr[4:0]) return 1'b0;
        if (ext_mode && (i[3] != model_addr[5])) return 1'b0;
        if (!cb && model_addr[4:0] == 5'd0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic do_reset(input logic [5:0] c0, input logic [5:0] c1);
        addr_copy0 = c0; addr_copy1 = c1; rx_valid = 1'b0; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 frame_valid in reset", 32'(frame_valid), 0);
        chk("R1 tx_active in reset", 32'(tx_active), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        model_addr = (c0 == c1) ? c0 : 6'd0;
        chk("R1 tx_bit idle", 32'(tx_bit), 1);
        chk("R1 addr_match idle", 32'(addr_match), 0);
        chk("R8 slave_addr", 32'(slave_addr), 32'(model_addr));
        chk("R8 addr_fault", 32'(addr_fault), 32'(c0 != c1));
    endtask

    // Send one request (with noisy idle gaps, R4) and check decode and response.
    task automatic run_req(input string tag, input logic cb, input logic [4:0] a,
                           input logic [4:0] i, input int kind, input logic [3:0] ri);
        logic [13:0] f;
        logic        ok, em, quiet;
        logic [6:0]  r;
        f  = mk(cb, a, i, kind);
        ok = (kind == 0);
        em = ok && model_match(cb, a, i);
        resp_info = ri;
        for (int b = 13; b >= 0; b--) begin
            repeat ($urandom % 3) begin
                rx_valid = 1'b0; rx_bit = 1'($urandom);
                @(posedge clk); #1;
            end
            rx_valid = 1'b1; rx_bit = f[b];
            @(posedge clk); #1;
        end
        rx_valid = 1'b0;
        chk(ok ? {tag, " R2 frame_valid"} : {tag, " R3 rejected"}, 32'(frame_valid), 32'(ok));
        if (ok) begin
            chk({tag, " R2 fields"}, {21'd0, req_ctrl, req_addr, req_info}, {21'd0, cb, a, i});
            chk({tag, " match"}, 32'(addr_match), 32'(em));
        end
        @(posedge clk); #1;
        chk({tag, " R2 pulse ends"}, 32'(frame_valid), 0);
        if (em) begin
            r = {1'b0, ri, ^ri, 1'b1};
            for (int k = 0; k < 7; k++) begin
                chk({tag, " R9 tx bit"}, {30'd0, tx_active, tx_bit}, {30'd0, 1'b1, r[6-k]});
                @(posedge clk); #1;
            end
            chk({tag, " R9 tx end"}, {30'd0, tx_active, tx_bit}, 32'd1);
        end else begin
            quiet = 1'b1;
            repeat (8) begin
                if (tx_active) quiet = 1'b0;
                @(posedge clk); #1;
            end
            chk({tag, " R10 silent"}, 32'(quiet), 1);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        // Agreeing copies: Sel=1, address 13.
        do_reset(6'b1_01101, 6'b1_01101);
        ext_mode = 1'b0;
        run_req("R5 i3=0", 1'b0, 5'd13, 5'b00101, 0, 4'b1010);
        run_req("R5 i3=1", 1'b0, 5'd13, 5'b01101, 0, 4'b0111);
        run_req("R4 noisy gaps", 1'b0, 5'd13, 5'b11111, 0, 4'b0001);
        run_req("R10 other addr", 1'b0, 5'd12, 5'b01000, 0, 4'b1111);
        ext_mode = 1'b1;
        run_req("R6 sel mismatch", 1'b0, 5'd13, 5'b00110, 0, 4'b1100);
        run_req("R6 sel match", 1'b0, 5'd13, 5'b01110, 0, 4'b1100);
        run_req("R3 bad start", 1'b0, 5'd13, 5'b01110, 1, 4'b0011);
        run_req("R3 bad end", 1'b0, 5'd13, 5'b01110, 2, 4'b0011);
        run_req("R3 bad parity", 1'b1, 5'd13, 5'b01110, 3, 4'b0011);
        // Copies after reset are ignored.
        addr_copy0 = 6'd3; addr_copy1 = 6'd9;
        @(posedge clk); #1;
        chk("R8 copies ignored after reset", 32'(slave_addr), 32'(model_addr));
        // Disagreeing copies: fault, address zero.
        ext_mode = 1'b0;
        do_reset(6'b0_00101, 6'b0_00100);
        run_req("R7 zero data", 1'b0, 5'd0, 5'b00000, 0, 4'b0101);
        run_req("R7 zero command", 1'b1, 5'd0, 5'b00010, 0, 4'b0110);
        // Random traffic.
        do_reset(6'b0_10110, 6'b0_10110);
        for (int n = 0; n < 60; n++) begin
            logic [4:0] a;
            int kind;
            ext_mode = 1'($urandom);
            a = ($urandom % 2) ? model_addr[4:0] : 5'($urandom);
            kind = ($urandom % 5 == 0) ? int'(1 + $urandom % 3) : 0;
            run_req("rand R5 R6", 1'($urandom), a, 5'($urandom), kind, 4'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule